// File: doc/BRIEF.md
# Voltage-Code Settle and Fault Blanking Timer

This block sits between the six voltage-identification pins of a multiphase regulator controller and the reference DAC. The code on those pins may be stepped up or down while the regulator carries load. Because the bits do not all switch at the same instant, the block synchronises them and holds the DAC code until the pins have stayed at one value for a minimum settle time. Only then does it pass the new code to the DAC.

Every code change also opens a much longer blanking window. While the window is open, the power-good flag is forced to its good state and the overvoltage crowbar request is forced off. This keeps the output swing caused by the voltage transition from raising a false fault. Each further change restarts both the settle time and the blanking window, so a ramp made of many small steps is covered by one continuous blanking window that ends one full window after the last step.

Both windows are given in nanoseconds and converted to clock cycles, rounded up, so the minimum times are always met. The live fault flags pass through unchanged whenever no window is open.

Top module: `vid_settle_blank`

## Requirements
- R1: While reset is held, `dac_code` is 0 and no blanking window is open. At the third clock edge after reset is released, `dac_code` takes the synchronised pin value. Priming in this way opens no blanking window.
- R2: A change on `vid_raw` applied between two edges first appears on `dac_code` at the (SETTLE_CYC + 3)th rising edge after it: two synchroniser edges, one detection edge, then SETTLE_CYC edges of settle time. It does not appear at any earlier edge.
- R3: A further change before the settle time ends restarts the settle count. A code that is replaced before it has settled never reaches `dac_code`.
- R4: A change opens a blanking window from the 3rd rising edge after it, and the window stays open through the (BLANK_CYC + 2)th edge. The window is measured from the most recent change.
- R5: While a window is open, `pgood_out` is 1 whatever the value of `pgood_raw`, and `crowbar_out` is 0 whatever the value of `crowbar_raw`.
- R6: While no window is open, `pgood_out` equals `pgood_raw` and `crowbar_out` equals `crowbar_raw`, with no clock delay.
- R7: SETTLE_CYC = ceil(SETTLE_NS × CLK_HZ / 1e9) and BLANK_CYC = ceil(BLANK_NS × CLK_HZ / 1e9). A time that is not a whole number of cycles is rounded up.
- R8: A change of any bit or combination of bits, toward a higher or lower code, is handled the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vid_raw | input | 6 | Asynchronous voltage-identification pins |
| pgood_raw | input | 1 | Live power-good flag from the comparator |
| crowbar_raw | input | 1 | Live overvoltage crowbar request |
| dac_code | output | 6 | Settled code delivered to the DAC |
| pgood_out | output | 1 | Power-good after blanking |
| crowbar_out | output | 1 | Crowbar request after blanking |

## Verification
The first stimulus is a single upward step, sampled one edge before and one edge at the expected load and window-end edges. This pins down the latency through the synchroniser, the detector and both counters, including the rounding up. A three-step ramp shows whether the timers restart at each step and whether the intermediate codes are skipped. A short excursion to a full-ones code followed by a downward step to a scattered bit pattern separates "last stable code" from "most recent change". Finally, a reset inside an open window checks that priming restores the code without reopening blanking, and toggling the fault flags inside and outside windows tells masking apart from pass-through.

// File: rtl/vsb_pkg.sv
package vsb_pkg;
  localparam int VID_W = 6;
  typedef logic [VID_W-1:0] vid_code_t;

  // Whole cycles covering at least ns nanoseconds at clk_hz, rounded up, never below one.
  function automatic int ns_to_cycles(input longint ns, input longint clk_hz);
    longint prod;
    longint cyc;
    prod = ns * clk_hz;
    cyc  = (prod + 64'd999_999_999) / 64'd1_000_000_000;
    if (cyc < 1) cyc = 1;
    return int'(cyc);
  endfunction
endpackage

// File: rtl/vsb_sync.sv
module vsb_sync #(
  parameter int W      = 6,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] pipe [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) pipe[s] <= '0;
        else     pipe[s] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) pipe[s] <= '0;
        else     pipe[s] <= pipe[s-1];
      end
    end
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/vsb_timer.sv
module vsb_timer #(
  parameter int LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic active,
  output logic expire
);
  localparam int CW = $clog2(LEN + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                cnt <= '0;
    else if (restart)       cnt <= CW'(LEN);
    else if (cnt != '0)     cnt <= cnt - CW'(1);
  end

  assign active = (cnt != '0);
  assign expire = (cnt == CW'(1)) && !restart;
endmodule

// File: rtl/vsb_fault_mask.sv
module vsb_fault_mask (
  input  logic blank,
  input  logic pgood_in,
  input  logic crowbar_in,
  output logic pgood_q,
  output logic crowbar_q
);
  always_comb begin
    if (blank) begin
      pgood_q   = 1'b1;
      crowbar_q = 1'b0;
    end else begin
      pgood_q   = pgood_in;
      crowbar_q = crowbar_in;
    end
  end
endmodule

// File: rtl/vid_settle_blank.sv
module vid_settle_blank #(
  parameter longint CLK_HZ    = 125_000_000,
  parameter longint SETTLE_NS = 400,
  parameter longint BLANK_NS  = 250_000,
  parameter int     SYNC_STG  = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [vsb_pkg::VID_W-1:0] vid_raw,
  input  logic                    pgood_raw,
  input  logic                    crowbar_raw,
  output logic [vsb_pkg::VID_W-1:0] dac_code,
  output logic                    pgood_out,
  output logic                    crowbar_out
);
  import vsb_pkg::*;

  localparam int SETTLE_CYC = ns_to_cycles(SETTLE_NS, CLK_HZ);
  localparam int BLANK_CYC  = ns_to_cycles(BLANK_NS, CLK_HZ);
  localparam int FW         = $clog2(SYNC_STG + 1);

  vid_code_t      vid_s;
  vid_code_t      vid_prev;
  logic [FW-1:0]  fill;
  logic           primed;
  logic           chg;
  logic           settle_done;
  logic           settle_busy;
  logic           blank_act;
  logic           blank_done;

  vsb_sync #(.W(VID_W), .STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst(rst), .din(vid_raw), .dout(vid_s)
  );

  // Count edges until the synchroniser holds a real pin sample.
  always_ff @(posedge clk) begin
    if (rst)                         fill <= '0;
    else if (fill != FW'(SYNC_STG))  fill <= fill + FW'(1);
  end

  assign chg = primed && (vid_s != vid_prev);

  always_ff @(posedge clk) begin
    if (rst) begin
      primed   <= 1'b0;
      vid_prev <= '0;
      dac_code <= '0;
    end else if (!primed) begin
      if (fill == FW'(SYNC_STG)) begin
        primed   <= 1'b1;
        vid_prev <= vid_s;
        dac_code <= vid_s;
      end
    end else begin
      vid_prev <= vid_s;
      if (settle_done) dac_code <= vid_s;
    end
  end

  vsb_timer #(.LEN(SETTLE_CYC)) u_settle (
    .clk(clk), .rst(rst), .restart(chg), .active(settle_busy), .expire(settle_done)
  );

  vsb_timer #(.LEN(BLANK_CYC)) u_blank (
    .clk(clk), .rst(rst), .restart(chg), .active(blank_act), .expire(blank_done)
  );

  vsb_fault_mask u_mask (
    .blank(blank_act), .pgood_in(pgood_raw), .crowbar_in(crowbar_raw),
    .pgood_q(pgood_out), .crowbar_q(crowbar_out)
  );
endmodule

// File: rtl/vsb_checker.sv
module vsb_checker (
  input logic       clk,
  input logic       rst,
  input logic       chg,
  input logic       primed,
  input logic       blank_act,
  input logic [5:0] dac_code,
  input logic       pgood_raw,
  input logic       crowbar_raw,
  input logic       pgood_out,
  input logic       crowbar_out
);
  // R3: a fresh change holds the DAC code for the next cycle
  p_hold_on_change_r3: assert property (@(posedge clk) disable iff (rst)
    chg |=> $stable(dac_code));

  // R2: once primed, the DAC code only moves inside a window
  p_load_in_window_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(primed) && !$stable(dac_code)) |-> $past(blank_act));

  // R4: a change always leaves a window open afterwards
  p_window_opens_r4: assert property (@(posedge clk) disable iff (rst)
    chg |=> blank_act);

  // R1: priming does not open a window
  p_prime_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    ($rose(primed) && !$past(blank_act)) |-> !blank_act);

  // R5: masking inside a window
  p_pgood_masked_r5: assert property (@(posedge clk) disable iff (rst)
    blank_act |-> (pgood_out && !crowbar_out));

  // R6: pass-through outside a window
  p_pass_through_r6: assert property (@(posedge clk) disable iff (rst)
    !blank_act |-> (pgood_out == pgood_raw && crowbar_out == crowbar_raw));
endmodule

bind vid_settle_blank vsb_checker u_chk (
  .clk(clk), .rst(rst), .chg(chg), .primed(primed), .blank_act(blank_act),
  .dac_code(dac_code), .pgood_raw(pgood_raw), .crowbar_raw(crowbar_raw),
  .pgood_out(pgood_out), .crowbar_out(crowbar_out)
);

// File: tb/sim_vid_settle_blank.sv
module sim_vid_settle_blank;
  // 396 ns and 1996 ns at 125 MHz round up to 50 and 250 cycles (R7).
  localparam int SETTLE_EXP = 50;
  localparam int BLANK_EXP  = 250;
  localparam int NV = 17;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] vid_raw = 6'h15;
  logic       pgood_raw = 1'b0;
  logic       crowbar_raw = 1'b0;
  logic [5:0] dac_code;
  logic       pgood_out, crowbar_out;
  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  vid_settle_blank #(.CLK_HZ(125_000_000), .SETTLE_NS(396), .BLANK_NS(1996)) u0 (
    .clk(clk), .rst(rst), .vid_raw(vid_raw), .pgood_raw(pgood_raw),
    .crowbar_raw(crowbar_raw), .dac_code(dac_code),
    .pgood_out(pgood_out), .crowbar_out(crowbar_out)
  );

  // {gap edges, vid, pgood_raw, crowbar_raw, exp dac, exp pgood, exp crowbar, req}
  // gaps add up: each row is sampled after its gap, counted from the previous row.
  localparam logic [31:0] VEC [NV] = '{
    {8'd4,   6'h15, 1'b0, 1'b1, 6'h15, 1'b0, 1'b1, 8'd6}, // R6 quiet pass-through
    {8'd3,   6'h20, 1'b0, 1'b1, 6'h15, 1'b1, 1'b0, 8'd5}, // R5 window open at edge 3
    {8'd49,  6'h20, 1'b0, 1'b1, 6'h15, 1'b1, 1'b0, 8'd2}, // R2 edge 52: old code
    {8'd1,   6'h20, 1'b0, 1'b1, 6'h20, 1'b1, 1'b0, 8'd7}, // R7 edge 53: new code
    {8'd199, 6'h20, 1'b0, 1'b1, 6'h20, 1'b1, 1'b0, 8'd4}, // R4 edge 252: still open
    {8'd1,   6'h20, 1'b0, 1'b1, 6'h20, 1'b0, 1'b1, 8'd4}, // R4 edge 253: closed
    {8'd30,  6'h21, 1'b1, 1'b0, 6'h20, 1'b1, 1'b0, 8'd3}, // R3 ramp step 1
    {8'd30,  6'h22, 1'b1, 1'b0, 6'h20, 1'b1, 1'b0, 8'd3}, // R3 ramp step 2
    {8'd53,  6'h23, 1'b1, 1'b1, 6'h23, 1'b1, 1'b0, 8'd3}, // R3 only final step loads
    {8'd199, 6'h23, 1'b0, 1'b1, 6'h23, 1'b1, 1'b0, 8'd4}, // R4 window from last step
    {8'd1,   6'h23, 1'b0, 1'b1, 6'h23, 1'b0, 1'b1, 8'd4}, // R4 closes
    {8'd5,   6'h3F, 1'b0, 1'b0, 6'h23, 1'b1, 1'b0, 8'd8}, // R8 all bits up, brief
    {8'd52,  6'h0C, 1'b0, 1'b0, 6'h23, 1'b1, 1'b0, 8'd3}, // R3 restarted settle
    {8'd1,   6'h0C, 1'b0, 1'b0, 6'h0C, 1'b1, 1'b0, 8'd8}, // R8 downward code loads
    {8'd199, 6'h0C, 1'b1, 1'b1, 6'h0C, 1'b1, 1'b0, 8'd5}, // R5 crowbar masked
    {8'd1,   6'h0C, 1'b1, 1'b1, 6'h0C, 1'b1, 1'b1, 8'd6}, // R6 crowbar passes
    {8'd2,   6'h0C, 1'b0, 1'b0, 6'h0C, 1'b0, 1'b0, 8'd6}  // R6 flags low pass
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    string rq;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "dac in reset", int'(dac_code), 0);
    rst = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "primed dac", int'(dac_code), 'h15);
    check("R1", "no window after prime", int'(pgood_out), 0);

    for (int i = 0; i < NV; i++) begin
      vid_raw     = VEC[i][23:18];
      pgood_raw   = VEC[i][17];
      crowbar_raw = VEC[i][16];
      repeat (int'(VEC[i][31:24])) @(posedge clk);
      @(negedge clk);
      rq = $sformatf("R%0d", VEC[i][7:0]);
      check(rq, $sformatf("row %0d dac", i), int'(dac_code), int'(VEC[i][15:10]));
      check(rq, $sformatf("row %0d pgood", i), int'(pgood_out), int'(VEC[i][9]));
      check(rq, $sformatf("row %0d crowbar", i), int'(crowbar_out), int'(VEC[i][8]));
    end

    // R1: reset inside an open window, then re-prime without blanking
    vid_raw = 6'h30; pgood_raw = 1'b0; crowbar_raw = 1'b1;
    repeat (10) @(posedge clk);
    @(negedge clk);
    check("R5", "window open before reset", int'(pgood_out), 1);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R1", "dac cleared by reset", int'(dac_code), 0);
    check("R1", "window cleared by reset", int'(crowbar_out), 1);
    rst = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1", "dac before third edge", int'(dac_code), 0);
    @(posedge clk);
    @(negedge clk);
    check("R1", "dac after re-prime", int'(dac_code), 'h30);
    repeat (5) @(posedge clk);
    @(negedge clk);
    check("R1", "prime opens no window", int'(pgood_out), 0);
    check("R2", "settle period length", SETTLE_EXP + 3, 53);
    summary();
  end
endmodule